// File: doc/BRIEF.md
# Power Controller Configuration Register with Two-Wire Serial Slave

This block is a two-wire serial bus (I2C) slave that owns one 8-bit configuration and status byte for a supply and tone controller. A host writes the six upper bits to select output enable, voltage level, cable-drop compensation, tone enable, transmit-path routing and the overcurrent protection style. On a read the host gets those six bits back, together with two live fault flags: over-temperature and overload. The six stored bits leave the block on a parallel output so that the analog blocks can use them directly.

The slave's 7-bit address has five fixed upper bits, `00010`. The two lower bits come from a board strap, so four controllers can share one bus. SCL and SDA come in raw. A two-stage synchronizer brings them into the system clock domain, and the system clock must run at least eight times faster than SCL. The slave drives the bus only by pulling SDA low. While the supply-good input is low, the stored bits are held at zero and the slave stays off the bus.

Top module: `pwr_reg_i2c_slave`

## Requirements
- R1: The slave answers a START followed by an address byte whose upper seven bits equal `0,0,0,1,0,strap[1],strap[0]` (MSB first). It answers by pulling SDA low for the whole ninth clock. Bit 0 of the address byte selects the direction: 1 is read, 0 is write.
- R2: In a write, the slave acknowledges the first byte after the address. Bits 7..2 of that byte become `cfg_o[5:0]`: bit 7 is pulsed-limit mode, then transmit path, tone enable, drop compensation, high voltage, and bit 2 is output enable.
- R3: Bits 1..0 of a written byte are discarded. In a read, byte bit 1 is `temp_alarm_i` and bit 0 is `overload_i`, both sampled when that byte starts to be sent.
- R4: In a read, the slave sends `{cfg_o, temp_alarm_i, overload_i}` MSB first. When the master pulls SDA low on the ninth clock, the slave sends another byte. When the master leaves SDA high there, the slave releases SDA and does not drive it again until the next START.
- R5: In a write, every byte after the first data byte goes unacknowledged and leaves `cfg_o` unchanged.
- R6: A STOP or START that arrives before the eighth bit of a data byte discards the partial byte and leaves `cfg_o` unchanged. A STOP returns the slave to idle with SDA released. A START begins a new address phase.
- R7: While `supply_ok_i` is low, `cfg_o` reads zero from the next cycle on, SDA is not pulled, and no byte is acknowledged. When the supply returns, `cfg_o` is still zero.
- R8: During reset and just after it, `cfg_o` is zero and SDA is released.
- R9: After an address byte that does not match, the slave acknowledges nothing and ignores the bus until the next START.
- R10: The slave starts pulling SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock from the bus |
| sda_i | input | 1 | Raw serial data level seen on the bus |
| strap_i | input | 2 | Board strap; sets the two low address bits |
| supply_ok_i | input | 1 | High when the supply is above the lockout threshold |
| temp_alarm_i | input | 1 | Live over-temperature flag, read back as bit 1 |
| overload_i | input | 1 | Live overload flag, read back as bit 0 |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain enable) |
| cfg_o | output | 6 | Stored configuration bits, byte bits 7..2 |

## Verification
A stimulus table covers all four strap values, each with a matching write address. Its data bytes have alternating, sparse and all-ones patterns, so a swapped or shifted bit lands in the wrong `cfg_o` position and shows up. Other rows use an address that differs from the expected one only in the strap bits, or only in the fixed bits, which separates the two halves of the address comparison. A write of a byte with only bits 1..0 set shows whether the low bits are discarded. The fault flags change from row to row, which shows whether readback takes them live or from storage. Directed sequences cover the ACK and NACK paths of a multi-byte read, an extra write byte, START and STOP arriving mid-byte, supply loss and reset.

// File: rtl/pwr_i2c_pkg.sv
`timescale 1ns/1ps
package pwr_i2c_pkg;

    // Byte engine states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ACK   = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4,
        ST_RACK  = 3'd5,
        ST_RNEXT = 3'd6,
        ST_SKIP  = 3'd7
    } slv_state_e;

    // What follows the acknowledge slot the slave is driving
    typedef enum logic [1:0] {
        NX_READ  = 2'd0,
        NX_WRITE = 2'd1,
        NX_DONE  = 2'd2
    } ack_next_e;

endpackage

// File: rtl/i2c_in_sync.sv
`timescale 1ns/1ps
module i2c_in_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // One flop chain per bit; bus lines idle high, so reset to RST_VAL
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= {STAGES{RST_VAL[g]}};
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    // Data edges only count as framing when SCL stayed high across them
    assign start_det =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_det  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;

endmodule

// File: rtl/pwr_reg_fsm.sv
`timescale 1ns/1ps
module pwr_reg_fsm
    import pwr_i2c_pkg::*;
#(
    parameter int WR_BITS   = 6,
    parameter int DIAG_BITS = 2,
    parameter int ADDR_W    = 7,
    parameter int STRAP_W   = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 5'b00010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_ok,
    input  logic [STRAP_W-1:0]   strap,
    input  logic [DIAG_BITS-1:0] diag,
    input  logic                 sda_s,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 sda_pull,
    output logic [WR_BITS-1:0]   cfg
);

    localparam int BYTE_W = WR_BITS + DIAG_BITS;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        slv_state_e          st;
        ack_next_e           nx;
        logic                ack_on;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sh;
        logic                pull;
        logic [WR_BITS-1:0]  cfg;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [BYTE_W-1:0] rx_byte;
    logic [ADDR_W-1:0] my_addr;
    logic [BYTE_W-1:0] rd_word;
    logic              last_bit;

    assign rx_byte  = {s_q.sh[BYTE_W-2:0], sda_s};
    assign my_addr  = {ADDR_FIXED, strap};
    assign rd_word  = {s_q.cfg, diag};
    assign last_bit = (s_q.cnt == LAST_BIT);

    always_comb begin
        s_d = s_q;
        if (!supply_ok) begin
            // Lockout: everything back to the power-on state
            s_d = '0;
        end else if (stop_det) begin
            s_d.st     = ST_IDLE;
            s_d.pull   = 1'b0;
            s_d.ack_on = 1'b0;
        end else if (start_det) begin
            s_d.st     = ST_ADDR;
            s_d.cnt    = '0;
            s_d.pull   = 1'b0;
            s_d.ack_on = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        s_d.sh  = rx_byte;
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                        if (last_bit) begin
                            s_d.cnt = '0;
                            if (rx_byte[BYTE_W-1:1] == my_addr) begin
                                s_d.st = ST_ACK;
                                s_d.nx = rx_byte[0] ? NX_READ : NX_WRITE;
                            end else begin
                                s_d.st = ST_SKIP;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        s_d.sh  = rx_byte;
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                        if (last_bit) begin
                            s_d.cnt = '0;
                            s_d.cfg = rx_byte[BYTE_W-1:DIAG_BITS];
                            s_d.st  = ST_ACK;
                            s_d.nx  = NX_DONE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!s_q.ack_on) begin
                            s_d.pull   = 1'b1;
                            s_d.ack_on = 1'b1;
                        end else begin
                            s_d.ack_on = 1'b0;
                            s_d.pull   = 1'b0;
                            s_d.cnt    = '0;
                            unique case (s_q.nx)
                                NX_READ: begin
                                    s_d.sh   = rd_word;
                                    s_d.pull = ~rd_word[BYTE_W-1];
                                    s_d.st   = ST_RDATA;
                                end
                                NX_WRITE: s_d.st = ST_WDATA;
                                default:  s_d.st = ST_SKIP;
                            endcase
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                        if (last_bit) begin
                            s_d.cnt = '0;
                            s_d.st  = ST_RACK;
                        end
                    end else if (scl_fall) begin
                        s_d.sh   = s_q.sh << 1;
                        s_d.pull = ~s_q.sh[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        s_d.pull = 1'b0;
                    end else if (scl_rise) begin
                        s_d.st = sda_s ? ST_SKIP : ST_RNEXT;
                    end
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        s_d.sh   = rd_word;
                        s_d.pull = ~rd_word[BYTE_W-1];
                        s_d.cnt  = '0;
                        s_d.st   = ST_RDATA;
                    end
                end
                default: begin
                    s_d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_pull = s_q.pull;
    assign cfg      = s_q.cfg;

endmodule

// File: rtl/pwr_reg_i2c_slave.sv
`timescale 1ns/1ps
module pwr_reg_i2c_slave #(
    parameter int WR_BITS    = 6,
    parameter int ADDR_W     = 7,
    parameter int STRAP_W    = 2,
    parameter int SYNC_DEPTH = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 5'b00010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               supply_ok_i,
    input  logic               temp_alarm_i,
    input  logic               overload_i,
    output logic               sda_pull_o,
    output logic [WR_BITS-1:0] cfg_o
);

    localparam int DIAG_BITS = 2;

    logic [1:0] bus_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    i2c_in_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pwr_reg_fsm #(
        .WR_BITS    (WR_BITS),
        .DIAG_BITS  (DIAG_BITS),
        .ADDR_W     (ADDR_W),
        .STRAP_W    (STRAP_W),
        .ADDR_FIXED (ADDR_FIXED)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok_i),
        .strap     (strap_i),
        .diag      ({temp_alarm_i, overload_i}),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull_o),
        .cfg       (cfg_o)
    );

endmodule

// File: rtl/pwr_reg_i2c_chk.sv
`timescale 1ns/1ps
module pwr_reg_i2c_chk #(
    parameter int WR_BITS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               supply_ok_i,
    input logic               scl_s,
    input logic               scl_rise,
    input logic               stop_det,
    input logic               sda_pull_o,
    input logic [WR_BITS-1:0] cfg_o
);

    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (cfg_o == '0 && !sda_pull_o));

    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_s));

    p_pull_needs_supply_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(supply_ok_i));

    p_cfg_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o != $past(cfg_o)) |-> ($past(scl_rise) || !$past(supply_ok_i)));

    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && supply_ok_i) |=> !sda_pull_o);

endmodule

bind pwr_reg_i2c_slave pwr_reg_i2c_chk #(.WR_BITS(WR_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok_i (supply_ok_i),
    .scl_s       (scl_s),
    .scl_rise    (scl_rise),
    .stop_det    (stop_det),
    .sda_pull_o  (sda_pull_o),
    .cfg_o       (cfg_o)
);

// File: tb/pwr_reg_i2c_slave_tb.sv
`timescale 1ns/1ps
module pwr_reg_i2c_slave_tb;

    localparam int HALF  = 8;
    localparam int LIMIT = 150000;
    localparam int NVEC  = 7;

    // {strap[1:0], addr_byte[7:0], data_byte[7:0], ack_addr, ack_data, cfg_expected[5:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'b00, 8'h10, 8'hFF, 1'b1, 1'b1, 6'h3F},
        {2'b01, 8'h12, 8'hA5, 1'b1, 1'b1, 6'h29},
        {2'b10, 8'h14, 8'h5A, 1'b1, 1'b1, 6'h16},
        {2'b11, 8'h16, 8'h81, 1'b1, 1'b1, 6'h20},
        {2'b11, 8'h10, 8'h00, 1'b0, 1'b0, 6'h20},
        {2'b00, 8'h30, 8'hFF, 1'b0, 1'b0, 6'h20},
        {2'b00, 8'h10, 8'h03, 1'b1, 1'b1, 6'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       supply_ok = 1'b1;
    logic       temp_alarm = 1'b0;
    logic       overload = 1'b0;
    logic       sda_pull_o;
    logic [5:0] cfg_o;
    logic       sda_bus;

    int checks = 0;
    int fails  = 0;
    int early_pull = 0;
    logic pull_prev = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull_o;

    pwr_reg_i2c_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .strap_i      (strap),
        .supply_ok_i  (supply_ok),
        .temp_alarm_i (temp_alarm),
        .overload_i   (overload),
        .sda_pull_o   (sda_pull_o),
        .cfg_o        (cfg_o)
    );

    // R10 monitor: the slave may start pulling only while SCL is low
    always @(negedge clk) begin
        if (rst_n && sda_pull_o && !pull_prev && m_scl) early_pull++;
        pull_prev = sda_pull_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b0; hold(HALF);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b1; hold(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_scl = 1'b0; hold(2);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF / 2);
        b = sda_bus;  hold(HALF - HALF / 2);
        m_scl = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic master_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~master_ack);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual cycles %0d expected fewer", LIMIT);
        summary();
        $finish;
    end

    initial begin
        logic       ack_a;
        logic       ack_d;
        logic [7:0] rb;
        logic [7:0] rb2;
        logic       b;

        hold(5);
        check("R8 cfg during reset", cfg_o, 6'h00);
        check("R8 sda during reset", sda_pull_o, 1'b0);
        rst_n = 1'b1;
        hold(5);
        check("R8 cfg after reset", cfg_o, 6'h00);
        check("R8 sda after reset", sda_pull_o, 1'b0);

        // Table walk: write, then read back at the strap's own address
        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            strap      = v[25:24];
            temp_alarm = i[0];
            overload   = i[1];
            hold(4);
            bus_start();
            send_byte(v[23:16], ack_a);
            send_byte(v[15:8], ack_d);
            bus_stop();
            check(v[7] ? "R1 address ack" : "R9 foreign address ignored", ack_a, v[7]);
            check(v[7] ? "R2 data ack" : "R9 data after foreign address", ack_d, v[6]);
            check(v[15:8] == 8'h03 ? "R3 low bits discarded" : "R2 cfg bits", cfg_o, v[5:0]);
            bus_start();
            send_byte({5'b00010, v[25:24], 1'b1}, ack_a);
            recv_byte(rb, 1'b0);
            bus_stop();
            check("R1 read address ack", ack_a, 1'b1);
            check("R3 R4 readback byte", rb, {v[5:0], i[0], i[1]});
        end

        // Multi-byte read: ACK, ACK, NACK, then slave silent
        strap = 2'b00; temp_alarm = 1'b1; overload = 1'b0;
        bus_start();
        send_byte(8'h10, ack_a);
        send_byte(8'hB4, ack_d);
        bus_stop();
        check("R2 cfg 2D", cfg_o, 6'h2D);
        bus_start();
        send_byte(8'h11, ack_a);
        recv_byte(rb, 1'b1);
        recv_byte(rb2, 1'b1);
        check("R4 first byte", rb, 8'hB6);
        check("R4 byte after master ack", rb2, 8'hB6);
        recv_byte(rb2, 1'b0);
        check("R4 third byte", rb2, 8'hB6);
        ack_a = 1'b0;
        for (int k = 0; k < 9; k++) begin
            get_bit(b);
            if (!b) ack_a = 1'b1;
        end
        check("R4 released after nack", ack_a, 1'b0);
        bus_stop();

        // Extra byte in a write
        bus_start();
        send_byte(8'h10, ack_a);
        send_byte(8'hC0, ack_d);
        check("R2 data ack C0", ack_d, 1'b1);
        send_byte(8'hFC, ack_d);
        bus_stop();
        check("R5 extra byte not acked", ack_d, 1'b0);
        check("R5 extra byte no effect", cfg_o, 6'h30);

        // STOP inside a data byte
        bus_start();
        send_byte(8'h10, ack_a);
        for (int k = 0; k < 4; k++) put_bit(1'b1);
        bus_stop();
        check("R6 stop mid byte keeps cfg", cfg_o, 6'h30);
        check("R6 stop releases sda", sda_pull_o, 1'b0);

        // START inside a data byte, then a fresh transaction
        bus_start();
        send_byte(8'h10, ack_a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        check("R6 start mid byte keeps cfg", cfg_o, 6'h30);
        send_byte(8'h10, ack_a);
        send_byte(8'h44, ack_d);
        bus_stop();
        check("R6 address after restart acked", ack_a, 1'b1);
        check("R6 write after restart", cfg_o, 6'h11);

        // Supply lockout
        supply_ok = 1'b0;
        hold(3);
        check("R7 cfg cleared in lockout", cfg_o, 6'h00);
        bus_start();
        send_byte(8'h10, ack_a);
        send_byte(8'hFC, ack_d);
        bus_stop();
        check("R7 no ack in lockout", ack_a, 1'b0);
        check("R7 no data ack in lockout", ack_d, 1'b0);
        supply_ok = 1'b1;
        hold(3);
        check("R7 cfg zero after supply returns", cfg_o, 6'h00);

        // Reset with a nonzero register
        bus_start();
        send_byte(8'h10, ack_a);
        send_byte(8'hFC, ack_d);
        bus_stop();
        check("R2 cfg 3F before reset", cfg_o, 6'h3F);
        rst_n = 1'b0;
        hold(3);
        check("R8 reset clears cfg", cfg_o, 6'h00);
        rst_n = 1'b1;
        hold(3);

        check("R10 pull started while SCL high", early_pull, 0);

        summary();
        $finish;
    end

endmodule